// File: doc/BRIEF.md
# Dual-Channel Sampled-Data Output Stage

This block forms the digital back end of a two-channel 8-bit sampling converter. On every rising clock edge it takes one raw word for channel A and one for channel B, carries both through a fixed-length delay, and presents them on two parallel output buses. The raw words are in offset-binary form. A single select input chooses whether each bus carries offset binary or two's complement, which is the same word with its top bit inverted.

Each bus has a per-bit drive-enable that models a high-impedance output. An output-disable input releases both buses. The power-down and sleep inputs freeze the delay line and the presented words. After any freeze or reset, a valid flag stays low until the delay line has refilled with fresh samples.

Top module: `dual_adc_outif`

## Requirements
- R1: Both channels take a new sample on every rising edge on which neither power-down nor sleep is high. Each channel's output carries only that channel's samples.
- R2: A sample present at the inputs at a running rising edge appears on the outputs after the fifth running edge, counting that edge as the first.
- R3: With `fmt_twos_i` low, the presented word equals the raw offset-binary sample. Mid-scale 8'h80, full scale 8'hFF and 8'h00 pass through unchanged.
- R4: With `fmt_twos_i` high, the presented word is the raw sample with bit 7 inverted, so 8'h80 becomes 8'h00, 8'hFF becomes 8'h7F and 8'h00 becomes 8'h80. The select is sampled at the output edge, so a change affects the next presented word and the delay line is not flushed.
- R5: With `out_hiz_i` high, every bit of both drive-enables is 0. With it low, every bit is 1. The data words are unaffected either way.
- R6: While `pd_i` is high, the delay line does not advance and both output words hold the value they had before power-down.
- R7: While `sleep_i` is high, both channels are disabled: the delay line does not advance and the output words hold.
- R8: `valid_o` goes low on the edge after a power-down or sleep cycle, or after reset. It returns high after five consecutive running edges.
- R9: A synchronous reset sets every delay stage and both output words to 8'h80 and clears `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_a_i | input | 8 | Raw offset-binary sample, channel A |
| smp_b_i | input | 8 | Raw offset-binary sample, channel B |
| fmt_twos_i | input | 1 | Output coding: 0 offset binary, 1 two's complement |
| out_hiz_i | input | 1 | 1 releases both buses (high impedance) |
| pd_i | input | 1 | Power-down: freeze pipeline and outputs |
| sleep_i | input | 1 | Sleep: channels disabled, pipeline and outputs frozen |
| dat_a_o | output | 8 | Presented word, channel A |
| drv_a_o | output | 8 | Per-bit drive-enable, channel A |
| dat_b_o | output | 8 | Presented word, channel B |
| drv_b_o | output | 8 | Per-bit drive-enable, channel B |
| valid_o | output | 1 | Presented words come from fresh samples |

## Verification
The assertions assume that every input is a synchronous level that is settled at each rising edge. They also assume that reset is held high from time zero until at least one edge has passed, so that the history the properties compare against is defined. The bench meets both assumptions. It changes samples and controls only at falling edges, and it starts with reset high for several cycles. The freeze and valid properties also assume that power-down and sleep can arrive on any cycle, and the stimulus applies them in the middle of a filled pipeline.

// File: rtl/dual_adc_pkg.sv
package dual_adc_pkg;
   localparam int unsigned NCH = 2;

   typedef enum logic {
      CODE_OFFSET = 1'b0,
      CODE_TWOS   = 1'b1
   } code_e;
endpackage

// File: rtl/adc_delay_line.sv
module adc_delay_line #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

   generate
      if (DEPTH == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_regs
         logic [W-1:0] stg [DEPTH];

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) stg[i] <= MID;
            end else if (en) begin
               stg[0] <= d_i;
               for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
            end
         end

         assign q_o = stg[DEPTH-1];

         // R6: a frozen line keeps its tail word
         a_r6_line_frozen: assert property (@(posedge clk) disable iff (rst)
            !en |=> $stable(q_o));
      end
   endgenerate
endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage
   import dual_adc_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  code_e        code_i,
   input  logic         hiz_i,
   input  logic [W-1:0] src_i,
   output logic [W-1:0] word_o,
   output logic [W-1:0] drv_o
);
   localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MSBM = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] coded;

   always_comb begin
      coded = src_i;
      if (code_i == CODE_TWOS) coded = src_i ^ MSBM;
   end

   always_ff @(posedge clk) begin
      if (rst)     word_o <= MID;
      else if (en) word_o <= coded;
   end

   assign drv_o = {W{~hiz_i}};

   // R4: the coding never touches the bits below the MSB
   a_r4_low_bits_pass: assert property (@(posedge clk) disable iff (rst)
      en |=> (word_o[W-2:0] == $past(src_i[W-2:0])));

   // R6: a frozen output register holds its word
   a_r6_word_held: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(word_o));
endmodule

// File: rtl/adc_valid_track.sv
module adc_valid_track #(
   parameter int unsigned LAT = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic valid_o
);
   localparam int unsigned CW = $clog2(LAT + 1);
   localparam logic [CW-1:0] LAT_C = CW'(LAT);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (rst || !en)          run_cnt <= '0;
      else if (run_cnt != LAT_C) run_cnt <= run_cnt + 1'b1;
   end

   assign valid_o = (run_cnt == LAT_C);

   // R8: any frozen cycle drops the flag on the next edge
   a_r8_clear_on_stall: assert property (@(posedge clk) disable iff (rst)
      !en |=> !valid_o);

   // R8: the flag only rises after a running edge
   a_r8_rise_after_run: assert property (@(posedge clk) disable iff (rst)
      $rose(valid_o) |-> $past(en));
endmodule

// File: rtl/dual_adc_outif.sv
module dual_adc_outif
   import dual_adc_pkg::*;
#(
   parameter int unsigned W   = 8,
   parameter int unsigned LAT = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] smp_a_i,
   input  logic [W-1:0] smp_b_i,
   input  logic         fmt_twos_i,
   input  logic         out_hiz_i,
   input  logic         pd_i,
   input  logic         sleep_i,
   output logic [W-1:0] dat_a_o,
   output logic [W-1:0] drv_a_o,
   output logic [W-1:0] dat_b_o,
   output logic [W-1:0] drv_b_o,
   output logic         valid_o
);
   localparam int unsigned LINE_DEPTH = LAT - 1;

   generate
      if (LAT < 2) begin : g_bad_lat
         $error("dual_adc_outif: LAT must be at least 2");
      end
      if (W < 2) begin : g_bad_w
         $error("dual_adc_outif: W must be at least 2");
      end
   endgenerate

   logic  run_en;
   code_e code_sel;

   assign run_en   = ~(pd_i | sleep_i);
   assign code_sel = fmt_twos_i ? CODE_TWOS : CODE_OFFSET;

   logic [W-1:0] raw  [NCH];
   logic [W-1:0] tail [NCH];
   logic [W-1:0] word [NCH];
   logic [W-1:0] drv  [NCH];

   assign raw[0] = smp_a_i;
   assign raw[1] = smp_b_i;

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
         adc_delay_line #(.W(W), .DEPTH(LINE_DEPTH)) u_line (
            .clk (clk),
            .rst (rst),
            .en  (run_en),
            .d_i (raw[ch]),
            .q_o (tail[ch])
         );

         adc_out_stage #(.W(W)) u_out (
            .clk    (clk),
            .rst    (rst),
            .en     (run_en),
            .code_i (code_sel),
            .hiz_i  (out_hiz_i),
            .src_i  (tail[ch]),
            .word_o (word[ch]),
            .drv_o  (drv[ch])
         );
      end
   endgenerate

   adc_valid_track #(.LAT(LAT)) u_valid (
      .clk     (clk),
      .rst     (rst),
      .en      (run_en),
      .valid_o (valid_o)
   );

   assign dat_a_o = word[0];
   assign dat_b_o = word[1];
   assign drv_a_o = drv[0];
   assign drv_b_o = drv[1];

   // R6: power-down freezes both buses at the port
   a_r6_pd_freeze: assert property (@(posedge clk) disable iff (rst)
      pd_i |=> ($stable(dat_a_o) && $stable(dat_b_o)));

   // R7: sleep freezes both buses at the port
   a_r7_sleep_freeze: assert property (@(posedge clk) disable iff (rst)
      sleep_i |=> ($stable(dat_a_o) && $stable(dat_b_o)));

   // R5: both buses are released or driven together
   a_r5_drive_match: assert property (@(posedge clk) disable iff (rst)
      (drv_a_o == drv_b_o) && $onehot0(drv_a_o ^ drv_b_o));
endmodule

// File: tb/tb_dual_adc_outif.sv
`timescale 1ns/1ps
module tb_dual_adc_outif;
   localparam int LAT = 5;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] smp_a = 8'h00, smp_b = 8'h00;
   logic       fmt = 1'b0, hiz = 1'b0, pd = 1'b0, slp = 1'b0;
   logic [7:0] dat_a, drv_a, dat_b, drv_b;
   logic       valid;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   dual_adc_outif dut (
      .clk(clk), .rst(rst), .smp_a_i(smp_a), .smp_b_i(smp_b),
      .fmt_twos_i(fmt), .out_hiz_i(hiz), .pd_i(pd), .sleep_i(slp),
      .dat_a_o(dat_a), .drv_a_o(drv_a), .dat_b_o(dat_b), .drv_b_o(drv_b),
      .valid_o(valid)
   );

   // behavioural reference: queues of pending samples, a run counter
   logic [7:0] qa[$], qb[$];
   logic [7:0] exp_a = 8'h80, exp_b = 8'h80;
   int         run = 0;

   always @(posedge clk) begin
      logic [7:0] ha, hb;
      if (rst) begin
         qa.delete(); qb.delete();
         for (int i = 0; i < LAT - 1; i++) begin
            qa.push_back(8'h80); qb.push_back(8'h80);
         end
         exp_a = 8'h80; exp_b = 8'h80; run = 0;
      end else if (!(pd || slp)) begin
         ha = qa.pop_back(); hb = qb.pop_back();
         exp_a = fmt ? {~ha[7], ha[6:0]} : ha;
         exp_b = fmt ? {~hb[7], hb[6:0]} : hb;
         qa.push_front(smp_a); qb.push_front(smp_b);
         if (run < LAT) run = run + 1;
      end else begin
         run = 0;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic compare(input string tag);
      logic [7:0] edrv;
      edrv = hiz ? 8'h00 : 8'hFF;
      chk(dat_a == exp_a, tag, dat_a, exp_a);
      chk(dat_b == exp_b, "R1", dat_b, exp_b);
      chk(drv_a == edrv && drv_b == edrv, "R5", {drv_a, drv_b}, {edrv, edrv});
      chk(valid == (run >= LAT), "R8", valid, (run >= LAT));
   endtask

   task automatic step(input string tag, input logic [7:0] a, input logic [7:0] b);
      @(negedge clk);
      compare(tag);
      smp_a = a; smp_b = b;
   endtask

   task automatic rnd_steps(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, 8'($urandom), 8'($urandom));
   endtask

   initial begin
      // R9: reset state
      for (int i = 0; i < 3; i++) step("R9", 8'h11, 8'h22);
      chk(dat_a == 8'h80 && dat_b == 8'h80 && !valid, "R9", {dat_a, dat_b}, 16'h8080);
      rst = 1'b0;

      // R3: offset-binary corners, then R2 latency with random data
      step("R9", 8'h80, 8'h7F);
      step("R9", 8'hFF, 8'h00);
      step("R9", 8'h00, 8'hFF);
      step("R9", 8'h01, 8'h80);
      step("R9", 8'h7F, 8'h01);
      for (int i = 0; i < 5; i++) step("R3", 8'($urandom), 8'($urandom));
      rnd_steps("R2", 40);

      // R4: two's complement corners and mid-stream select changes
      fmt = 1'b1;
      step("R4", 8'h80, 8'h00);
      step("R4", 8'hFF, 8'h80);
      step("R4", 8'h00, 8'hFF);
      rnd_steps("R4", 10);
      for (int i = 0; i < 20; i++) begin
         if (i % 3 == 0) fmt = ~fmt;
         step("R4", 8'($urandom), 8'($urandom));
      end

      // R5: output release toggled while data keeps flowing
      for (int i = 0; i < 20; i++) begin
         hiz = 1'($urandom);
         step("R5", 8'($urandom), 8'($urandom));
      end
      hiz = 1'b0;

      // R6: power-down in a full pipeline, with changing inputs and select
      pd = 1'b1;
      for (int i = 0; i < 6; i++) begin
         if (i == 2) fmt = ~fmt;
         step("R6", 8'($urandom), 8'($urandom));
      end
      pd = 1'b0;
      rnd_steps("R8", 8);

      // R7: sleep behaves as a freeze too
      slp = 1'b1;
      rnd_steps("R7", 6);
      slp = 1'b0;
      rnd_steps("R8", 3);
      pd = 1'b1;
      step("R6", 8'h55, 8'hAA);
      pd = 1'b0;
      rnd_steps("R8", 8);

      // R9: reset in mid-run
      rst = 1'b1;
      rnd_steps("R9", 2);
      rst = 1'b0;
      rnd_steps("R9", 7);

      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule